// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the register-write front end of a legacy-style programmable interrupt controller. It receives byte writes to a two-address window, where `wr_addr` 0 selects the base location and `wr_addr` 1 selects base+1. It sorts each write into one of these kinds: a start of initialization, a follow-on initialization word, a mask update, or an operation command. It then updates the configuration fields that the controller core reads.

A write to the base location with data bit 4 set always starts initialization, even when a sequence is already in progress. Starting initialization masks nothing and clears the edge-detect latches. It also returns the priority, slave identity and status-read selection to their defaults. Three writes to base+1 must then follow, and they are taken as the second, third and fourth initialization words. Mask updates through base+1 and operation commands through the base location are accepted only after the fourth word.

Top module: `pic_init_seq`

## Requirements
- R1: A write with `wr_addr`=0 and data bit 4 = 1 starts initialization from any state. From the next cycle `init_busy`=1 and `init_done`=0, and an older unfinished sequence is abandoned.
- R2: After a start, the next three writes with `wr_addr`=1 are taken in order. The first loads `vector_base` from data bits 7:3. The second loads `cascade_map` with the whole byte and `slave_id` with data bits 2:0. The third loads `icw4_mode`. `init_done` rises, and `init_busy` falls, in the cycle after the third write and not before it.
- R3: `edge_clr` is high for exactly the one cycle after a start write, and it is low at all other times.
- R4: A start write clears `imr` to all zeros. After reset, `imr` is all ones.
- R5: A start write sets `lowest_prio` to 7 (IRQ7 has the lowest priority) and sets `slave_id` to 7.
- R6: A start write clears `special_mask` and `read_isr`. `read_isr`=0 means that a status read returns the request register.
- R7: `icw1_view` repeats the start byte with bit 3 forced to 1 and bit 2 forced to 0.
- R8: `cfg_error` is set by a start byte whose bit 1 (single mode) is 1 or whose bit 0 (fourth word required) is 0, and it is cleared by any other start byte. When bit 0 was 0, the fourth word is still consumed, but `icw4_mode` stays 0.
- R9: A `wr_addr`=1 write loads `imr` only while `init_done`=1. Before that, such a write never changes `imr`.
- R10: While `init_done`=1, a `wr_addr`=0 write with bit 4 = 0 is an operation command. With bit 3 = 0 and bits 7:5 = 110 it sets `lowest_prio` to bits 2:0. With bit 3 = 1 it does two things: when bit 1 = 1 it sets `read_isr` to bit 0, and when bit 6 = 1 it sets `special_mask` to bit 5. Before `init_done`, such writes have no effect.
- R11: After reset the sequencer is uninitialized: `init_busy`=0 and `init_done`=0, and writes to base+1 are ignored until a start write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 1 | 0 = base location, 1 = base+1 |
| wr_data | input | 8 | Write data |
| init_busy | output | 1 | Initialization sequence in progress |
| init_done | output | 1 | All four initialization words written |
| cfg_error | output | 1 | Start byte asked for single mode or omitted the fourth word |
| icw1_view | output | 8 | Start byte as read back |
| vector_base | output | 5 | Interrupt vector base bits |
| cascade_map | output | 8 | Third initialization word |
| slave_id | output | 3 | Slave identity |
| icw4_mode | output | 8 | Fourth initialization word, or 0 when it was not required |
| imr | output | 8 | Interrupt mask register |
| edge_clr | output | 1 | One-cycle reset pulse for the edge-detect latches |
| lowest_prio | output | 3 | IRQ number with the lowest priority |
| special_mask | output | 1 | Special mask mode |
| read_isr | output | 1 | Status read selects the in-service register (0 = request register) |

## Verification
If the sequence state is wrong, the first thing to show it at the ports is `init_done`. It rises one write early or late, and `vector_base`, `cascade_map` or `icw4_mode` then hold a byte that belongs to a different step. A mask write that is let through too early shows in `imr` one cycle after the offending write. A missed start side effect shows in `imr`, `edge_clr`, `lowest_prio`, `slave_id`, `special_mask` or `read_isr` in the very next cycle. A restart issued in the middle of a sequence is the sharpest test: a stale step counter puts the following bytes into the wrong fields.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;
  localparam int BYTE_W   = 8;
  localparam int SEL_BIT  = 4;
  localparam int OCW3_BIT = 3;
  localparam int LTIM_BIT = 3;
  localparam int ADI_BIT  = 2;
  localparam int SNGL_BIT = 1;
  localparam int IC4_BIT  = 0;
  localparam logic [2:0] OCW2_SET_PRIO = 3'b110;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_W2     = 3'd1,
    ST_W3     = 3'd2,
    ST_W4     = 3'd3,
    ST_READY  = 3'd4
  } seq_state_e;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_ICW1 = 3'd1,
    WK_ICWN = 3'd2,
    WK_IMR  = 3'd3,
    WK_OCW2 = 3'd4,
    WK_OCW3 = 3'd5
  } wr_kind_e;
endpackage

// File: rtl/pic_rst_sync.sv
module pic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
  import pic_init_pkg::*;
(
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic       sel_bit,
  input  logic       ocw3_bit,
  input  seq_state_e state,
  output wr_kind_e   kind
);
  logic in_seq;
  assign in_seq = (state == ST_W2) || (state == ST_W3) || (state == ST_W4);

  always_comb begin
    kind = WK_NONE;
    if (wr_en) begin
      if (!wr_addr) begin
        if (sel_bit)                kind = WK_ICW1;
        else if (state == ST_READY) kind = ocw3_bit ? WK_OCW3 : WK_OCW2;
      end else begin
        if (in_seq)                 kind = WK_ICWN;
        else if (state == ST_READY) kind = WK_IMR;
      end
    end
  end
endmodule

// File: rtl/pic_seq_fsm.sv
module pic_seq_fsm
  import pic_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wr_kind_e   kind,
  output seq_state_e state
);
  seq_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    if (kind == WK_ICW1) begin
      state_d = ST_W2;
    end else if (kind == WK_ICWN) begin
      unique case (state_q)
        ST_W2:   state_d = ST_W3;
        ST_W3:   state_d = ST_W4;
        ST_W4:   state_d = ST_READY;
        default: state_d = state_q;
      endcase
    end
  end

  assign state_en = (kind == WK_ICW1) || (kind == WK_ICWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_UNINIT;
    else if (state_en) state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_init_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int PRIO_W = $clog2(NUM_IRQ),
  localparam int VEC_W  = BYTE_W - PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_kind_e          kind,
  input  seq_state_e        state,
  input  logic [BYTE_W-1:0] data,
  output logic [BYTE_W-1:0] icw1_view,
  output logic [VEC_W-1:0]  vector_base,
  output logic [BYTE_W-1:0] cascade_map,
  output logic [PRIO_W-1:0] slave_id,
  output logic [BYTE_W-1:0] icw4_mode,
  output logic [NUM_IRQ-1:0] imr,
  output logic              edge_clr,
  output logic [PRIO_W-1:0] lowest_prio,
  output logic              special_mask,
  output logic              read_isr,
  output logic              cfg_error
);
  logic [BYTE_W-1:0]  icw1_q, icw1_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic [BYTE_W-1:0]  cmap_q, cmap_d;
  logic [PRIO_W-1:0]  sid_q, sid_d;
  logic [BYTE_W-1:0]  icw4_q, icw4_d;
  logic [NUM_IRQ-1:0] imr_q, imr_d;
  logic               edge_q, edge_d;
  logic [PRIO_W-1:0]  prio_q, prio_d;
  logic               smm_q, smm_d;
  logic               ris_q, ris_d;
  logic               err_q, err_d;
  logic               upd_en;

  always_comb begin
    icw1_d = icw1_q;
    vec_d  = vec_q;
    cmap_d = cmap_q;
    sid_d  = sid_q;
    icw4_d = icw4_q;
    imr_d  = imr_q;
    edge_d = 1'b0;
    prio_d = prio_q;
    smm_d  = smm_q;
    ris_d  = ris_q;
    err_d  = err_q;
    unique case (kind)
      WK_ICW1: begin
        icw1_d           = data;
        icw1_d[LTIM_BIT] = 1'b1;
        icw1_d[ADI_BIT]  = 1'b0;
        imr_d            = '0;
        edge_d           = 1'b1;
        prio_d           = '1;
        sid_d            = '1;
        smm_d            = 1'b0;
        ris_d            = 1'b0;
        icw4_d           = '0;
        err_d            = data[SNGL_BIT] | ~data[IC4_BIT];
      end
      WK_ICWN: begin
        unique case (state)
          ST_W2: vec_d = data[BYTE_W-1:PRIO_W];
          ST_W3: begin
            cmap_d = data;
            sid_d  = data[PRIO_W-1:0];
          end
          ST_W4: icw4_d = icw1_q[IC4_BIT] ? data : '0;
          default: ;
        endcase
      end
      WK_IMR:  imr_d = data[NUM_IRQ-1:0];
      WK_OCW2: if (data[7:5] == OCW2_SET_PRIO) prio_d = data[PRIO_W-1:0];
      WK_OCW3: begin
        if (data[1]) ris_d = data[0];
        if (data[6]) smm_d = data[5];
      end
      default: ;
    endcase
  end

  assign upd_en = (kind != WK_NONE) || edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icw1_q <= '0;
      vec_q  <= '0;
      cmap_q <= '0;
      sid_q  <= '0;
      icw4_q <= '0;
      imr_q  <= '1;
      edge_q <= 1'b0;
      prio_q <= '1;
      smm_q  <= 1'b0;
      ris_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (upd_en) begin
      icw1_q <= icw1_d;
      vec_q  <= vec_d;
      cmap_q <= cmap_d;
      sid_q  <= sid_d;
      icw4_q <= icw4_d;
      imr_q  <= imr_d;
      edge_q <= edge_d;
      prio_q <= prio_d;
      smm_q  <= smm_d;
      ris_q  <= ris_d;
      err_q  <= err_d;
    end
  end

  assign icw1_view    = icw1_q;
  assign vector_base  = vec_q;
  assign cascade_map  = cmap_q;
  assign slave_id     = sid_q;
  assign icw4_mode    = icw4_q;
  assign imr          = imr_q;
  assign edge_clr     = edge_q;
  assign lowest_prio  = prio_q;
  assign special_mask = smm_q;
  assign read_isr     = ris_q;
  assign cfg_error    = err_q;
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_init_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int PRIO_W = $clog2(NUM_IRQ),
  localparam int VEC_W  = BYTE_W - PRIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic               init_busy,
  output logic               init_done,
  output logic               cfg_error,
  output logic [BYTE_W-1:0]  icw1_view,
  output logic [VEC_W-1:0]   vector_base,
  output logic [BYTE_W-1:0]  cascade_map,
  output logic [PRIO_W-1:0]  slave_id,
  output logic [BYTE_W-1:0]  icw4_mode,
  output logic [NUM_IRQ-1:0] imr,
  output logic               edge_clr,
  output logic [PRIO_W-1:0]  lowest_prio,
  output logic               special_mask,
  output logic               read_isr
);
  logic       rst_n_s;
  seq_state_e seq_state;
  wr_kind_e   wr_kind;

  pic_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  pic_wr_decode u_decode (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .sel_bit  (wr_data[SEL_BIT]),
    .ocw3_bit (wr_data[OCW3_BIT]),
    .state    (seq_state),
    .kind     (wr_kind)
  );

  pic_seq_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n_s),
    .kind  (wr_kind),
    .state (seq_state)
  );

  pic_cfg_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .kind         (wr_kind),
    .state        (seq_state),
    .data         (wr_data),
    .icw1_view    (icw1_view),
    .vector_base  (vector_base),
    .cascade_map  (cascade_map),
    .slave_id     (slave_id),
    .icw4_mode    (icw4_mode),
    .imr          (imr),
    .edge_clr     (edge_clr),
    .lowest_prio  (lowest_prio),
    .special_mask (special_mask),
    .read_isr     (read_isr),
    .cfg_error    (cfg_error)
  );

  assign init_busy = (seq_state == ST_W2) || (seq_state == ST_W3) || (seq_state == ST_W4);
  assign init_done = (seq_state == ST_READY);
endmodule

// File: rtl/pic_init_seq_chk.sv
module pic_init_seq_chk
  import pic_init_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int PRIO_W = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               wr_addr,
  input logic               sel_bit,
  input logic               sngl_bit,
  input logic               ic4_bit,
  input seq_state_e         seq_state,
  input logic               init_busy,
  input logic               init_done,
  input logic               cfg_error,
  input logic [NUM_IRQ-1:0] imr,
  input logic               edge_clr,
  input logic [PRIO_W-1:0]  lowest_prio,
  input logic [PRIO_W-1:0]  slave_id,
  input logic               special_mask,
  input logic               read_isr
);
  logic start_wr;
  assign start_wr = wr_en && !wr_addr && sel_bit;

  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (init_busy && !init_done));

  p_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_W4 && wr_en && wr_addr) |=> (init_done && !init_busy));

  p_edge_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> edge_clr);

  p_edge_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start_wr |=> !edge_clr);

  p_mask_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (imr == '0));

  p_prio_slave_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (lowest_prio == '1 && slave_id == '1));

  p_status_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (!special_mask && !read_isr));

  p_cfg_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (cfg_error == ($past(sngl_bit) || !$past(ic4_bit))));

  p_mask_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && wr_en && wr_addr) |=> $stable(imr));
endmodule

bind pic_init_seq pic_init_seq_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .sel_bit      (wr_data[4]),
  .sngl_bit     (wr_data[1]),
  .ic4_bit      (wr_data[0]),
  .seq_state    (seq_state),
  .init_busy    (init_busy),
  .init_done    (init_done),
  .cfg_error    (cfg_error),
  .imr          (imr),
  .edge_clr     (edge_clr),
  .lowest_prio  (lowest_prio),
  .slave_id     (slave_id),
  .special_mask (special_mask),
  .read_isr     (read_isr)
);

// File: tb/pic_init_seq_bench.sv
`timescale 1ns/1ps
module pic_init_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       init_busy, init_done, cfg_error, edge_clr, special_mask, read_isr;
  logic [7:0] icw1_view, cascade_map, icw4_mode, imr;
  logic [4:0] vector_base;
  logic [2:0] slave_id, lowest_prio;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_init_seq u_pic_init_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .init_busy(init_busy), .init_done(init_done), .cfg_error(cfg_error),
    .icw1_view(icw1_view), .vector_base(vector_base), .cascade_map(cascade_map),
    .slave_id(slave_id), .icw4_mode(icw4_mode), .imr(imr), .edge_clr(edge_clr),
    .lowest_prio(lowest_prio), .special_mask(special_mask), .read_isr(read_isr)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R11 busy after reset", init_busy, 0);
    check("R11 done after reset", init_done, 0);
    check("R4 imr reset all ones", imr, 8'hFF);
    check("R3 edge_clr idle after reset", edge_clr, 0);
    wr(1'b1, 8'h55);
    check("R11 base+1 ignored when uninitialized", imr, 8'hFF);
    check("R11 still not done", init_done, 0);
    wr(1'b0, 8'hC3);
    check("R10 command ignored when uninitialized", lowest_prio, 3'd7);
  endtask

  task automatic t_basic_init();
    wr(1'b0, 8'h11);
    check("R3 edge_clr pulse", edge_clr, 1);
    check("R1 busy after start", init_busy, 1);
    check("R4 imr cleared", imr, 8'h00);
    check("R5 lowest_prio 7", lowest_prio, 3'd7);
    check("R5 slave_id 7", slave_id, 3'd7);
    check("R7 icw1_view bit3 set", icw1_view, 8'h19);
    check("R8 no cfg error", cfg_error, 0);
    idle();
    check("R3 edge_clr one cycle only", edge_clr, 0);
    wr(1'b1, 8'h20);
    check("R2 vector_base", vector_base, 5'h04);
    check("R9 imr untouched by init word", imr, 8'h00);
    wr(1'b1, 8'h04);
    check("R2 cascade_map", cascade_map, 8'h04);
    check("R2 slave_id from third word", slave_id, 3'd4);
    check("R2 not done before fourth", init_done, 0);
    wr(1'b1, 8'h01);
    check("R2 icw4_mode", icw4_mode, 8'h01);
    check("R2 done after fourth", init_done, 1);
    check("R2 busy cleared", init_busy, 0);
    check("R9 imr untouched by fourth word", imr, 8'h00);
  endtask

  task automatic t_mask_write();
    wr(1'b1, 8'hA5);
    check("R9 imr loaded when done", imr, 8'hA5);
    wr(1'b1, 8'h3C);
    check("R9 imr second load", imr, 8'h3C);
  endtask

  task automatic t_commands();
    wr(1'b0, 8'hC3);
    check("R10 specific priority", lowest_prio, 3'd3);
    wr(1'b0, 8'h25);
    check("R10 other command leaves priority", lowest_prio, 3'd3);
    wr(1'b0, 8'h0B);
    check("R10 read_isr set", read_isr, 1);
    wr(1'b0, 8'h68);
    check("R10 special mask set", special_mask, 1);
    check("R10 read_isr kept without RR", read_isr, 1);
    wr(1'b0, 8'h15);
    check("R7 icw1_view bit2 dropped", icw1_view, 8'h19);
    check("R6 special mask cleared", special_mask, 0);
    check("R6 read_isr cleared", read_isr, 0);
    check("R5 priority back to 7", lowest_prio, 3'd7);
    check("R4 imr cleared again", imr, 8'h00);
    wr(1'b0, 8'hC2);
    check("R10 command ignored mid-sequence", lowest_prio, 3'd7);
    wr(1'b1, 8'h08); wr(1'b1, 8'h02); wr(1'b1, 8'h03);
    check("R2 done again", init_done, 1);
  endtask

  task automatic t_restart();
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h40);
    wr(1'b0, 8'h11);
    check("R1 restart busy", init_busy, 1);
    wr(1'b1, 8'h08);
    check("R1 restarted vector_base", vector_base, 5'h01);
    wr(1'b1, 8'h02);
    check("R1 not done after two words", init_done, 0);
    check("R1 slave_id after restart", slave_id, 3'd2);
    wr(1'b1, 8'h03);
    check("R1 done after restarted sequence", init_done, 1);
    check("R1 icw4 from restarted sequence", icw4_mode, 8'h03);
    wr(1'b0, 8'h11);
    check("R1 start from done", init_busy, 1);
    check("R1 done dropped", init_done, 0);
  endtask

  task automatic t_cfg_error();
    wr(1'b0, 8'h13);
    check("R8 single mode error", cfg_error, 1);
    wr(1'b0, 8'h10);
    check("R8 missing fourth word error", cfg_error, 1);
    wr(1'b1, 8'h10); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    check("R8 icw4 forced zero", icw4_mode, 8'h00);
    check("R8 still consumed fourth word", init_done, 1);
    wr(1'b0, 8'h11);
    check("R8 error cleared by good start", cfg_error, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_basic_init();
    t_mask_write();
    t_commands();
    t_restart();
    t_cfg_error();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule